// File: doc/BRIEF.md
# Non-Maskable Interrupt Input Conditioner

This block takes one external non-maskable interrupt pin and turns its transitions into a request for the CPU. The pin is first brought into the clock domain by a two-stage synchroniser. An optional glitch filter then accepts a level change only after it has held for a programmed number of cycles. Rising edges, falling edges or both then count as events, each direction with its own enable. An accepted event sets a sticky pending flag. A second event that arrives while the flag is still set raises an overrun flag. Software clears both flags with a one-cycle strobe.

The pending event is sent to one of three destinations. The first is a recoverable critical-interrupt level. The second is a machine-check request that lasts one cycle. The third is a machine-check request that stays asserted until the flag is cleared, so that no other critical exception can overwrite the saved state. A wakeup request can also be produced while an event is pending.

All settings sit in one configuration word. Once that word has been written with its enable bit set, it is frozen until reset. Later writes, including attempts to disable the function, cannot suppress the request.

Top module: `nmi_cond`

## Requirements
- R1: With the filter disabled, a pin transition sampled at rising clock edge k shows on the request outputs just after edge k+3. With the filter enabled and length L, it shows just after edge k+L+2.
- R2: The filter enable is configuration bit 1, and the filter length is L = bits[10:7] + 1, which gives 1 to 16. A pin level held for fewer than L cycles produces no event. A level held for L or more cycles produces an event.
- R3: Configuration bit 2 enables rising-edge events and bit 3 enables falling-edge events. A transition whose direction is not enabled produces no event.
- R4: An event sets a pending flag that stays set until `clr_i` is pulsed. The flag is cleared at the clock edge that samples `clr_i` high, unless a new event arrives in the same cycle.
- R5: An event that arrives while the pending flag is set raises `ovr_o`. `ovr_o` stays high until `clr_i` is pulsed.
- R6: Once the configuration has been written with bit 0 (enable) set, every later configuration write is ignored until reset. This includes writes that clear the enable bit.
- R7: The destination is selected by bits[6:5]. Value 0 or 3 drives `crit_req_o` high while the flag is pending. Value 1 pulses `mchk_req_o` for one cycle when the flag is set. Value 2 holds `mchk_req_o` high until the flag is cleared. `crit_req_o` and `mchk_req_o` are never high together.
- R8: Configuration bit 4 enables `wake_req_o`, which is then high while the flag is pending. When bit 4 is clear, `wake_req_o` stays low.
- R9: After reset, all outputs are low and the configuration is all zero.
- R10: While configuration bit 0 is clear, no event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw non-maskable interrupt pin |
| clr_i | input | 1 | Write-one strobe that clears the pending and overrun flags |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 11 | Configuration word |
| crit_req_o | output | 1 | Critical-interrupt request |
| mchk_req_o | output | 1 | Machine-check request |
| wake_req_o | output | 1 | Wakeup request |
| ovr_o | output | 1 | Overrun flag |

## Verification
A pin change reaches the outputs after two synchroniser edges, L filter edges and one flag edge. The bench drives the pin on a falling clock edge and counts rising edges from there. For the latency cases it samples on the falling edge right after edge L+2 and right after edge L+3, expecting the request to be absent and then present. A flag clear is due one edge after the strobe, and the one-cycle machine-check pulse must have dropped one edge after it appears. Each of these is sampled on the falling edge that follows. Table-driven cases and the lock test sample only after a wait long enough for any filtered event to have settled.

// File: rtl/nmi_cond_pkg.sv
package nmi_cond_pkg;
  localparam int unsigned FLT_CNT_W = 4;

  typedef enum logic [1:0] {
    DEST_CRIT      = 2'd0,
    DEST_MCHK      = 2'd1,
    DEST_MCHK_HOLD = 2'd2,
    DEST_CRIT_ALT  = 2'd3
  } dest_e;

  typedef struct packed {
    logic [FLT_CNT_W-1:0] flt_len_m1;
    dest_e                dest;
    logic                 wake_en;
    logic                 fall_en;
    logic                 rise_en;
    logic                 flt_en;
    logic                 en;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/nmi_cond_sync.sv
module nmi_cond_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nmi_cond_filter.sv
module nmi_cond_filter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_m1_i,
  input  logic             d_i,
  output logic             q_o
);
  logic             q_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      q_q   <= d_i;
      cnt_q <= '0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == len_m1_i) begin
      // level held for the full window
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/nmi_cond_edge.sv
module nmi_cond_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic d_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign evt_o = arm_i & ((rise_en_i & d_i & ~prev_q) |
                          (fall_en_i & ~d_i & prev_q));
endmodule

// File: rtl/nmi_cond.sv
module nmi_cond
  import nmi_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             clr_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             crit_req_o,
  output logic             mchk_req_o,
  output logic             wake_req_o,
  output logic             ovr_o
);
  cfg_t cfg_q;
  logic pin_s, pin_f, evt;
  logic flag_q, ovr_q, first_q;

  // configuration freezes once enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cfg_q <= '0;
    else if (cfg_we_i && !cfg_q.en) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  nmi_cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  nmi_cond_filter #(.CNT_W(FLT_CNT_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_q.flt_en),
    .len_m1_i(cfg_q.flt_len_m1),
    .d_i     (pin_s),
    .q_o     (pin_f)
  );

  nmi_cond_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (cfg_q.en),
    .rise_en_i(cfg_q.rise_en),
    .fall_en_i(cfg_q.fall_en),
    .d_i      (pin_f),
    .evt_o    (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      ovr_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      flag_q  <= evt | (flag_q & ~clr_i);
      ovr_q   <= (evt & flag_q) | (ovr_q & ~clr_i);
      first_q <= evt & ~flag_q;
    end
  end

  always_comb begin
    crit_req_o = 1'b0;
    mchk_req_o = 1'b0;
    unique case (cfg_q.dest)
      DEST_MCHK:                crit_req_o = 1'b0;
      DEST_MCHK_HOLD:           crit_req_o = 1'b0;
      DEST_CRIT, DEST_CRIT_ALT: crit_req_o = flag_q;
      default:                  crit_req_o = 1'b0;
    endcase
    if (cfg_q.dest == DEST_MCHK)      mchk_req_o = first_q;
    if (cfg_q.dest == DEST_MCHK_HOLD) mchk_req_o = flag_q;
  end

  assign wake_req_o = flag_q & cfg_q.wake_en;
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/nmi_cond_chk.sv
module nmi_cond_chk
  import nmi_cond_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic evt,
  input logic flag_q,
  input logic ovr_q,
  input cfg_t cfg_q,
  input logic crit_req_o,
  input logic mchk_req_o,
  input logic wake_req_o
);
  p_cfg_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en |=> $stable(cfg_q));

  p_no_evt_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.en |-> !evt);

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);

  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !evt |=> !flag_q && !ovr_q);

  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && evt |=> ovr_q);

  p_dest_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crit_req_o, mchk_req_o}));

  p_wake_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> cfg_q.wake_en && flag_q);
endmodule

bind nmi_cond nmi_cond_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .evt       (evt),
  .flag_q    (flag_q),
  .ovr_q     (ovr_q),
  .cfg_q     (cfg_q),
  .crit_req_o(crit_req_o),
  .mchk_req_o(mchk_req_o),
  .wake_req_o(wake_req_o)
);

// File: tb/nmi_cond_bench.sv
module nmi_cond_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned MAX_CYC    = 20000;
  localparam int unsigned NVEC       = 8;

  // {cfg[10:0], pulse width[4:0], expect {crit,mchk,wake,ovr}}
  localparam logic [19:0] VEC [NVEC] = '{
    {11'h005, 5'd1, 4'b1000},  // R1 R3 R8: rise, no filter, no wake
    {11'h187, 5'd3, 4'b0000},  // R2: L=4, too short
    {11'h187, 5'd4, 4'b1000},  // R2: L=4, exactly long enough
    {11'h009, 5'd2, 4'b1000},  // R3: falling only
    {11'h001, 5'd3, 4'b0000},  // R3: no direction enabled
    {11'h004, 5'd3, 4'b0000},  // R10: disabled
    {11'h055, 5'd2, 4'b0110},  // R7 R8: held machine check + wake
    {11'h065, 5'd2, 4'b1000}   // R7: code 3 acts as critical
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin = 1'b0;
  logic        clr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic        crit, mchk, wake, ovr;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_cond u_nmi_cond (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pin_i      (pin),
    .clr_i      (clr),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .crit_req_o (crit),
    .mchk_req_o (mchk),
    .wake_req_o (wake),
    .ovr_o      (ovr)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if ({crit, mchk, wake, ovr} !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {crit,mchk,wake,ovr}=%b expected %b", req, {crit, mchk, wake, ovr}, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    pin    = 1'b0;
    clr    = 1'b0;
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr_cfg(input logic [10:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic pulse(input int unsigned w);
    @(negedge clk);
    pin = 1'b1;
    repeat (w) @(negedge clk);
    pin = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // pin rises at a negedge; sample just after edge n and edge n+1
  task automatic latency(input logic [10:0] cfg, input int unsigned n, input string req,
                         input logic [3:0] exp_on);
    do_reset();
    wr_cfg(cfg);
    @(negedge clk);
    pin = 1'b1;
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk(req, 4'b0000);
    @(posedge clk);
    @(negedge clk);
    chk(req, exp_on);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset();
    @(negedge clk);
    chk("R9 reset outputs", 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr_cfg(VEC[i][19:9]);
      pulse(int'(VEC[i][8:4]));
      repeat (24) @(negedge clk);
      chk($sformatf("R2/R3/R7/R8/R10 vector %0d", i), VEC[i][3:0]);
    end

    // R1: latency without filter: request after edge 4
    latency(11'h005, 4, "R1 unfiltered latency", 4'b1000);
    // R1: filter L=5 (field 4): request after edge 8
    latency(11'h207, 8, "R1 filtered latency", 4'b1000);

    // R7: one-cycle machine-check pulse (dest 1)
    latency(11'h025, 4, "R7 mchk pulse rise", 4'b0100);
    @(negedge clk);
    chk("R7 mchk pulse drops", 4'b0000);

    // R4: sticky flag and clear
    do_reset();
    wr_cfg(11'h005);
    pulse(1);
    repeat (15) @(negedge clk);
    chk("R4 flag sticky", 4'b1000);
    strobe_clr();
    chk("R4 flag cleared", 4'b0000);

    // R5: overrun from rise then fall while pending
    do_reset();
    wr_cfg(11'h00D);
    pulse(2);
    repeat (10) @(negedge clk);
    chk("R5 overrun set", 4'b1001);
    strobe_clr();
    chk("R5 overrun cleared", 4'b0000);

    // R6: writes after enable are ignored, including disable
    do_reset();
    wr_cfg(11'h005);
    wr_cfg(11'h049);
    wr_cfg(11'h000);
    pulse(2);
    repeat (10) @(negedge clk);
    chk("R6 locked config still rise/critical", 4'b1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule